// File: doc/BRIEF.md
# Streaming Linear Grayscale Dilation and Erosion

This block filters a raster stream of grayscale pixels with a flat one-dimensional structuring element. The element covers the current pixel and the samples just before it on the same line. For every pixel that comes in, exactly one pixel goes out, carrying the maximum of those samples in dilation mode or the minimum in erosion mode. The work per pixel does not grow with the element length. A short queue holds the only samples that can still be the result, each tagged with its position on the line. The newest entries are removed one per cycle while the incoming pixel dominates them, meaning it is not smaller than them in dilation mode and not larger in erosion mode. The incoming pixel is then appended. The oldest entry is dropped once it has slid out of the window, and the oldest remaining entry is the result.

The element length `len` and the mode are captured with the first pixel of each line, so they can be changed between lines without touching the datapath. The input marks the last pixel of a line. That marker travels with the matching output pixel and empties the queue, so no sample leaks into the next line. Both streams use a valid/ready handshake. A transfer happens on a rising clock edge where valid and ready are both high. Once the output is valid, its data and marker stay unchanged until the output is accepted. `in_ready` depends on `out_ready` in the same cycle. It is low while an output is stalled and while the block is removing dominated entries. With no removals and no output back-pressure, one pixel per cycle is accepted.

Top module: `lindil_stream`

## Requirements
- R1: In dilation mode (`cfg_erode`=0), the output for the pixel at position k of a line (k counts from 0) is the maximum of the input samples at positions max(0, k-len+1) through k of that line.
- R2: In erosion mode (`cfg_erode`=1), the same window gives the minimum instead of the maximum.
- R3: `len` and the mode are sampled in the cycle the first pixel of a line is accepted, and are held for the whole line. Changes to `cfg_len` or `cfg_erode` later in the line have no effect on that line. A `cfg_len` of 0 acts as 1, and a value above MAX_LEN acts as MAX_LEN.
- R4: `out_eol` is high exactly on the output of a pixel accepted with `in_eol` high. The window never reaches across a line end: the first output of a line equals that line's first input.
- R5: Every accepted pixel produces exactly one output pixel, and outputs come in the order the inputs were accepted.
- R6: While `out_valid` is high and `out_ready` is low, `out_valid`, `out_data` and `out_eol` hold their values into the next cycle.
- R7: The block removes one dominated entry per cycle, and `in_ready` stays low while it does. An equal value counts as dominated. Each accepted pixel that finds a dominated entry in the queue causes at least one cycle with `in_ready` low. A line that never gives a dominated entry (strictly decreasing values in dilation mode, strictly increasing in erosion mode) is accepted at one pixel per cycle when `out_ready` is held high.
- R8: During and right after reset, `out_valid` is low and `in_ready` is high.
- R9: The queue never holds more than MAX_LEN entries. At `len`=MAX_LEN, a line longer than the window still gives correct results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_len | input | $clog2(MAX_LEN+1) | Structuring-element length, captured at line start |
| cfg_erode | input | 1 | 0 selects dilation (maximum), 1 selects erosion (minimum), captured at line start |
| in_valid | input | 1 | Input pixel present |
| in_ready | output | 1 | Block can take the input pixel this cycle |
| in_data | input | DW | Input pixel value, unsigned |
| in_eol | input | 1 | Input pixel is the last of its line |
| out_valid | output | 1 | Output pixel present |
| out_ready | input | 1 | Downstream takes the output pixel this cycle |
| out_data | output | DW | Filtered pixel value |
| out_eol | output | 1 | Output pixel closes its line |

## Verification
The bench goes after runs of equal pixels. A design that kept equal values in the queue would not stall on them, so the stall count would be wrong, and the queue could overflow. It also drives strictly decreasing lines at the largest length, where the ring wraps and the oldest entry is overwritten while it is being dropped. An off-by-one in the age test would shift each result by one position. Lengths of 0 and above the maximum, together with configuration changes in the middle of a line, expose a design that reads the configuration live or does not clamp it, because its window size would change partway through a line. Random back-pressure on both sides catches outputs that are lost, duplicated or altered while stalled, and a queue that is not cleared at a line end shows up as stale values leaking into the first pixels of the next line.

// File: rtl/lds_pkg.sv
package lds_pkg;
  // Control phases of the streaming filter.
  typedef enum logic {
    ST_TAKE  = 1'b0,  // ready for a new pixel
    ST_ERASE = 1'b1   // removing dominated entries for a held pixel
  } lds_state_e;
endpackage

// File: rtl/lds_ring.sv
// Circular candidate store: value plus line position per entry.
module lds_ring #(
  parameter int DW    = 8,
  parameter int PW    = 6,
  parameter int DEPTH = 16,
  parameter int CW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [DW-1:0] push_val,
  input  logic [PW-1:0] push_pos,
  input  logic          pop_head,
  input  logic          pop_tail,
  input  logic          clear,
  output logic [CW-1:0] cnt,
  output logic [DW-1:0] head_val,
  output logic [PW-1:0] head_pos,
  output logic [DW-1:0] next_val,
  output logic [DW-1:0] tail_val
);
  localparam int IW = $clog2(DEPTH);

  logic [DW-1:0] val_r [DEPTH];
  logic [PW-1:0] pos_r [DEPTH];
  logic [IW-1:0] hd_q, tl_q, wr_idx;
  logic [CW-1:0] cnt_q;

  function automatic logic [IW-1:0] step_up(input logic [IW-1:0] i);
    return (i == IW'(DEPTH - 1)) ? '0 : i + 1'b1;
  endfunction

  function automatic logic [IW-1:0] step_dn(input logic [IW-1:0] i);
    return (i == '0) ? IW'(DEPTH - 1) : i - 1'b1;
  endfunction

  // An empty ring keeps tail one slot behind head, so a push always lands after tail.
  assign wr_idx = step_up(tl_q);

  always_ff @(posedge clk) begin
    if (push) begin
      val_r[wr_idx] <= push_val;
      pos_r[wr_idx] <= push_pos;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hd_q  <= '0;
      tl_q  <= IW'(DEPTH - 1);
      cnt_q <= '0;
    end else if (clear) begin
      hd_q  <= '0;
      tl_q  <= IW'(DEPTH - 1);
      cnt_q <= '0;
    end else begin
      if (push)          tl_q <= wr_idx;
      else if (pop_tail) tl_q <= step_dn(tl_q);
      if (pop_head)      hd_q <= step_up(hd_q);
      cnt_q <= cnt_q + CW'(push) - CW'(pop_head) - CW'(pop_tail);
    end
  end

  assign cnt      = cnt_q;
  assign head_val = val_r[hd_q];
  assign head_pos = pos_r[hd_q];
  assign next_val = val_r[step_up(hd_q)];
  assign tail_val = val_r[tl_q];

  AST_RING_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CW'(DEPTH)); // R9
  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_head || pop_tail) |-> (cnt_q != '0)); // R9
  AST_NO_OVERRUN: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !pop_head && !clear) |-> (cnt_q < CW'(DEPTH))); // R9
endmodule

// File: rtl/lds_ctrl.sv
// Erase/commit sequencer, window ageing, result selection and output register.
module lds_ctrl import lds_pkg::*; #(
  parameter int DW      = 8,
  parameter int MAX_LEN = 16,
  parameter int LW      = $clog2(MAX_LEN + 1),
  parameter int PW      = LW + 1,
  parameter int CW      = $clog2(MAX_LEN + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [LW-1:0] cfg_len,
  input  logic          cfg_erode,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [DW-1:0] in_data,
  input  logic          in_eol,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [DW-1:0] out_data,
  output logic          out_eol,
  input  logic [CW-1:0] q_cnt,
  input  logic [DW-1:0] q_head_val,
  input  logic [PW-1:0] q_head_pos,
  input  logic [DW-1:0] q_next_val,
  input  logic [DW-1:0] q_tail_val,
  output logic          q_push,
  output logic [DW-1:0] q_cur_val,
  output logic [PW-1:0] q_pos,
  output logic          q_pop_head,
  output logic          q_pop_tail,
  output logic          q_clear
);
  lds_state_e    st_q;
  logic [DW-1:0] hold_val;
  logic          hold_eol;
  logic [LW-1:0] len_q, len_clamped, len_eff;
  logic          erode_q, erode_eff, sol_q;
  logic [PW-1:0] pos_q, age;
  logic [DW-1:0] cur_val, result;
  logic          cur_eol, slot_free, take, active, dominated, erase, commit, stale;

  // Length saturation: 0 behaves as 1, anything above the queue depth as the depth.
  assign len_clamped = (cfg_len == '0)             ? LW'(1) :
                       (cfg_len > LW'(MAX_LEN))    ? LW'(MAX_LEN) : cfg_len;
  assign len_eff   = sol_q ? len_clamped : len_q;
  assign erode_eff = sol_q ? cfg_erode   : erode_q;

  assign slot_free = !out_valid || out_ready;
  assign in_ready  = (st_q == ST_TAKE) && slot_free;
  assign take      = in_valid && in_ready;
  assign active    = (st_q == ST_ERASE) || take;
  assign cur_val   = (st_q == ST_ERASE) ? hold_val : in_data;
  assign cur_eol   = (st_q == ST_ERASE) ? hold_eol : in_eol;

  // Ties are dominated too, keeping the queue strictly monotone.
  assign dominated = erode_eff ? (q_tail_val >= cur_val) : (q_tail_val <= cur_val);
  assign erase     = active && (q_cnt != '0) && dominated;
  assign commit    = active && !erase && slot_free;

  // Modular age works because no live entry is older than MAX_LEN < 2**PW.
  assign age    = pos_q - q_head_pos;
  assign stale  = (q_cnt != '0) && (age >= PW'(len_eff));
  assign result = (q_cnt == '0)          ? cur_val :
                  !stale                 ? q_head_val :
                  (q_cnt >= CW'(2))      ? q_next_val : cur_val;

  assign q_push     = commit;
  assign q_cur_val  = cur_val;
  assign q_pos      = pos_q;
  assign q_pop_head = commit && stale;
  assign q_pop_tail = erase;
  assign q_clear    = commit && cur_eol;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q      <= ST_TAKE;
      hold_val  <= '0;
      hold_eol  <= 1'b0;
      len_q     <= LW'(1);
      erode_q   <= 1'b0;
      sol_q     <= 1'b1;
      pos_q     <= '0;
      out_valid <= 1'b0;
      out_data  <= '0;
      out_eol   <= 1'b0;
    end else begin
      if (take) begin
        hold_val <= in_data;
        hold_eol <= in_eol;
      end
      if (take && sol_q) begin
        len_q   <= len_clamped;
        erode_q <= cfg_erode;
      end
      if (commit) begin
        st_q      <= ST_TAKE;
        sol_q     <= cur_eol;
        pos_q     <= cur_eol ? '0 : pos_q + 1'b1;
        out_valid <= 1'b1;
        out_data  <= result;
        out_eol   <= cur_eol;
      end else begin
        if (erase) st_q <= ST_ERASE;
        if (out_ready) out_valid <= 1'b0;
      end
    end
  end

  AST_DIL_GE: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && !erode_eff) |-> (result >= cur_val)); // R1
  AST_ERO_LE: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && erode_eff) |-> (result <= cur_val)); // R2
  AST_CFG_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (!sol_q && $past(!sol_q)) |-> ($stable(len_q) && $stable(erode_q))); // R3
  AST_EOL_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && cur_eol) |=> (sol_q && q_cnt == '0)); // R4
  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_eol))); // R6
  AST_ERASE_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_ERASE) |-> !in_ready); // R7
endmodule

// File: rtl/lindil_stream.sv
// Streaming 1-D flat dilation/erosion with a runtime window length.
module lindil_stream #(
  parameter int DW      = 8,
  parameter int MAX_LEN = 16,
  parameter int LW      = $clog2(MAX_LEN + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [LW-1:0] cfg_len,
  input  logic          cfg_erode,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [DW-1:0] in_data,
  input  logic          in_eol,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [DW-1:0] out_data,
  output logic          out_eol
);
  localparam int PW = LW + 1;
  localparam int CW = $clog2(MAX_LEN + 1);

  logic [CW-1:0] q_cnt;
  logic [DW-1:0] q_head_val, q_next_val, q_tail_val, q_cur_val;
  logic [PW-1:0] q_head_pos, q_pos;
  logic          q_push, q_pop_head, q_pop_tail, q_clear;

  lds_ctrl #(.DW(DW), .MAX_LEN(MAX_LEN), .LW(LW), .PW(PW), .CW(CW)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .cfg_len(cfg_len), .cfg_erode(cfg_erode),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data), .in_eol(in_eol),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data), .out_eol(out_eol),
    .q_cnt(q_cnt), .q_head_val(q_head_val), .q_head_pos(q_head_pos),
    .q_next_val(q_next_val), .q_tail_val(q_tail_val),
    .q_push(q_push), .q_cur_val(q_cur_val), .q_pos(q_pos),
    .q_pop_head(q_pop_head), .q_pop_tail(q_pop_tail), .q_clear(q_clear)
  );

  lds_ring #(.DW(DW), .PW(PW), .DEPTH(MAX_LEN), .CW(CW)) u_ring (
    .clk(clk), .rst_n(rst_n), .push(q_push), .push_val(q_cur_val), .push_pos(q_pos),
    .pop_head(q_pop_head), .pop_tail(q_pop_tail), .clear(q_clear),
    .cnt(q_cnt), .head_val(q_head_val), .head_pos(q_head_pos),
    .next_val(q_next_val), .tail_val(q_tail_val)
  );
endmodule

// File: tb/sim_lindil_stream.sv
module sim_lindil_stream;
  localparam int DW      = 8;
  localparam int MAX_LEN = 16;
  localparam int LW      = $clog2(MAX_LEN + 1);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [LW-1:0] cfg_len = '0;
  logic          cfg_erode = 1'b0;
  logic          in_valid = 1'b0;
  logic          in_ready;
  logic [DW-1:0] in_data = '0;
  logic          in_eol = 1'b0;
  logic          out_valid;
  logic          out_ready = 1'b1;
  logic [DW-1:0] out_data;
  logic          out_eol;

  always #4 clk = ~clk;  // 125 MHz

  lindil_stream #(.DW(DW), .MAX_LEN(MAX_LEN)) u0 (
    .clk(clk), .rst_n(rst_n), .cfg_len(cfg_len), .cfg_erode(cfg_erode),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data), .in_eol(in_eol),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data), .out_eol(out_eol)
  );

  int    n_vec = 0, n_bad = 0;
  int    rdy_prob = 100;
  bit    done = 0;
  string tag = "R1";

  // Behavioural reference state.
  int line_q[$];
  int exp_v[$];
  bit exp_e[$];
  bit exp_r[$];
  bit ref_sol = 1;
  int ref_len = 1;
  bit ref_er = 0;
  bit held = 0;
  int held_d;
  bit held_e;

  task automatic check(input bit ok, input string req, input string what, input int got, input int exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, got, exp);
    end
  endtask

  // Downstream readiness, changed away from the clock edge.
  always begin
    @(posedge clk); #2;
    out_ready = (($urandom % 100) < rdy_prob);
  end

  // Monitor: sees each handshake half a period before the edge that completes it.
  always @(negedge clk) begin
    if (rst_n) begin
      if (held) begin
        check(out_valid && out_data == held_d[DW-1:0] && out_eol == held_e,
              "R6", "stalled output changed", int'(out_data), held_d);
      end
      held   = out_valid && !out_ready;
      held_d = int'(out_data);
      held_e = out_eol;

      if (in_valid && in_ready) begin
        int k, lo, acc;
        if (ref_sol) begin
          // R3: capture at line start, with clamping
          ref_len = (cfg_len == 0) ? 1 : ((int'(cfg_len) > MAX_LEN) ? MAX_LEN : int'(cfg_len));
          ref_er  = cfg_erode;
        end
        line_q.push_back(int'(in_data));
        k   = line_q.size() - 1;
        lo  = (k - ref_len + 1 < 0) ? 0 : k - ref_len + 1;
        acc = line_q[lo];
        for (int j = lo + 1; j <= k; j++)
          acc = ref_er ? ((line_q[j] < acc) ? line_q[j] : acc) : ((line_q[j] > acc) ? line_q[j] : acc);
        exp_v.push_back(acc);
        exp_e.push_back(in_eol);
        exp_r.push_back(ref_er);
        ref_sol = in_eol;
        if (in_eol) line_q.delete();
      end

      if (out_valid && out_ready) begin
        if (exp_v.size() == 0) begin
          check(0, "R5", "output with no pending input", int'(out_data), -1);
        end else begin
          int ev; bit ee, er;
          ev = exp_v.pop_front();
          ee = exp_e.pop_front();
          er = exp_r.pop_front();
          check(out_data == ev[DW-1:0], er ? {"R2 ", tag} : {"R1 ", tag}, "out_data", int'(out_data), ev);
          check(out_eol == ee, "R4", "out_eol", int'(out_eol), int'(ee));
        end
      end
    end
  end

  task automatic idle(input int n);
    in_valid = 1'b0;
    repeat (n) begin @(posedge clk); #2; end
  endtask

  // Sends one line; counts cycles where a presented pixel was not taken.
  task automatic send_line(input int vals[$], input int lcfg, input bit er, input int gap,
                           input bit mid, output int stalls);
    stalls = 0;
    for (int i = 0; i < vals.size(); i++) begin
      bit acc;
      while (gap > 0 && ($urandom % 100) < gap) begin
        in_valid = 1'b0; @(posedge clk); #2;
      end
      in_valid = 1'b1;
      in_data  = DW'(vals[i]);
      in_eol   = (i == vals.size() - 1);
      if (i == 0) begin
        cfg_len   = LW'(lcfg);
        cfg_erode = er;
      end
      acc = 0;
      while (!acc) begin
        @(negedge clk);
        if (in_ready) acc = 1; else stalls++;
        @(posedge clk); #2;
      end
      if (mid) begin
        cfg_len   = LW'($urandom);
        cfg_erode = 1'($urandom);
      end
    end
    in_valid = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL R5 watchdog expired, got %0d outputs pending expected 0", exp_v.size());
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    int v[$];
    int st;
    repeat (3) @(negedge clk);
    check(out_valid == 1'b0, "R8", "out_valid in reset", int'(out_valid), 0);
    @(posedge clk); #1 rst_n = 1'b1;
    @(negedge clk);
    check(out_valid == 1'b0, "R8", "out_valid after reset", int'(out_valid), 0);
    check(in_ready == 1'b1, "R8", "in_ready after reset", int'(in_ready), 1);
    @(posedge clk); #2;

    // R7: one rising pixel forces exactly one visible stall
    rdy_prob = 100; idle(5);
    v = '{10, 20, 5};
    send_line(v, 4, 0, 0, 0, st);
    check(st == 1, "R7", "stalls on rising pixel", st, 1);

    // R7: equal values are erased, each costing a cycle
    idle(5);
    v = '{7, 7, 7, 7};
    send_line(v, 3, 0, 0, 0, st);
    check(st == 2, "R7", "stalls on equal run", st, 2);

    // R9: full-depth window on a long strictly decreasing line, no stalls
    idle(5); tag = "R9";
    v.delete();
    for (int i = 0; i < 40; i++) v.push_back(220 - 3 * i);
    send_line(v, MAX_LEN, 0, 0, 0, st);
    check(st == 0, "R7", "stalls on decreasing dilation line", st, 0);

    // R2/R7: erosion on increasing data never erases
    idle(5); tag = "R2";
    v.delete();
    for (int i = 0; i < 25; i++) v.push_back(10 + 2 * i);
    send_line(v, 5, 1, 0, 0, st);
    check(st == 0, "R7", "stalls on increasing erosion line", st, 0);

    // R3: length 0, over-range length, mid-line configuration churn
    idle(5); tag = "R3";
    v.delete();
    for (int i = 0; i < 20; i++) v.push_back($urandom % 256);
    send_line(v, 0, 0, 0, 1, st);
    v.delete();
    for (int i = 0; i < 40; i++) v.push_back($urandom % 256);
    send_line(v, MAX_LEN + 3, 0, 0, 1, st);
    send_line(v, 2, 1, 0, 1, st);

    // Random traffic with back-pressure on both sides
    tag = "R5"; rdy_prob = 60;
    for (int ln = 0; ln < 300; ln++) begin
      int n;
      bit narrow;
      n = 1 + ($urandom % 40);
      narrow = (($urandom % 4) == 0);
      v.delete();
      for (int i = 0; i < n; i++) v.push_back(narrow ? ($urandom % 3) : ($urandom % 256));
      send_line(v, $urandom % (MAX_LEN + 4), 1'($urandom), 30, 1'($urandom), st);
    end

    rdy_prob = 100;
    idle(100);
    check(exp_v.size() == 0, "R5", "outputs still missing", exp_v.size(), 0);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule